// File: doc/BRIEF.md
# Pulse Period and Width Capture Timer

This block measures the time between transitions of an asynchronous measurement input, counted in ticks of a count-enable strobe. An up-counter advances on each tick while the timer runs. When an effective transition of the measurement input arrives, the counter value moves into a capture register, the counter restarts from zero, and a one-cycle interrupt request is raised. The counter wrapping past its maximum also raises a request and sets an overflow flag. Software reads that flag to tell the two causes apart.

Two measurement styles exist. Period mode uses one chosen polarity as the effective transition, so a capture holds the full period of the input. Width mode treats every transition as effective, so successive captures alternate between the high-phase length and the low-phase length. Configuration changes are accepted only while the timer is stopped. The one exception is clearing the overflow flag, which is possible only while running and only after the counter has seen a further tick after the overflow. The first effective transition after a start loads a meaningless value and raises no request.

Top module: `pulse_capture_timer`

## Requirements
- R1: After reset the timer is stopped, counter, capture and overflow flag read 0, no request is raised, and the configuration is period mode with rising polarity (cfg_width_o = 0, cfg_falling_o = 0).
- R2: A configuration write (cfg_we_i with cfg_width_i, cfg_falling_i) updates cfg_width_o and cfg_falling_o one cycle later only when the timer is stopped. While running, these fields are ignored.
- R3: While running, the counter increments by one, modulo 2^W, on each cycle with tick_i = 1. It holds its value when tick_i = 0 or when the timer is stopped.
- R4: An effective transition copies the counter into capture_o, sets the counter to 0 and raises irq_o for one cycle. All of this is visible 3 clock cycles after the measurement input changes: two synchronizer stages plus the update edge. The counter restarts even when tick_i = 1 in that cycle. A gap of N cycles between two effective transitions with a tick every cycle therefore captures N-1.
- R5: In period mode, cfg_falling = 0 makes only a 0-to-1 transition effective, and cfg_falling = 1 makes only a 1-to-0 transition effective. The opposite transition changes neither the counter, the capture nor irq_o.
- R6: In width mode, both transitions are effective, so consecutive captures hold the high-phase and low-phase lengths in turn.
- R7: The first effective transition after the timer is started still loads the capture register and restarts the counter, but raises no request.
- R8: A tick while running with the counter at 2^W-1 wraps the counter to 0, sets ovf_flag_o to 1 and raises irq_o. This happens even before the first transition after a start.
- R9: A configuration write with cfg_ovf_i = 0 clears the overflow flag only while running and only if at least one tick has occurred since the overflow. Otherwise the write is ignored. A write with cfg_ovf_i = 1 never changes the flag.
- R10: When an effective transition and an overflow tick fall in the same cycle, irq_o is raised for one cycle only, capture_o takes 2^W-1, the counter becomes 0 and the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| tick_i | input | 1 | Count-source strobe, one count per high cycle |
| meas_i | input | 1 | Asynchronous measurement input |
| start_we_i | input | 1 | Write strobe for the run bit |
| start_i | input | 1 | Run bit value (1 = counting) |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_width_i | input | 1 | 1 = width mode, 0 = period mode |
| cfg_falling_i | input | 1 | Period-mode polarity, 1 = falling |
| cfg_ovf_i | input | 1 | Overflow flag write value (0 requests clear) |
| running_o | output | 1 | Run bit |
| cfg_width_o | output | 1 | Current measurement mode |
| cfg_falling_o | output | 1 | Current period polarity |
| ovf_flag_o | output | 1 | Overflow status flag |
| count_o | output | W | Live counter value |
| capture_o | output | W | Last captured count |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
A change of meas_i reaches capture_o, count_o and irq_o three rising edges later. Counter, flag and configuration effects appear one edge after the tick or write that causes them. The bench drives and samples one nanosecond after each falling edge, and it waits exactly that many falling edges before comparing. Random width-mode gaps are checked against N-1, and the overflow and coincidence cases hold the counter with tick_i so that a transition and a wrapping tick land on the same edge. The request line is counted on every falling edge, so a doubled or missing pulse shows as a count mismatch.

// File: rtl/pmt_pkg.sv
`timescale 1ns/1ps
package pmt_pkg;
   typedef enum logic {
      MEAS_PERIOD = 1'b0,
      MEAS_WIDTH  = 1'b1
   } meas_mode_e;

   typedef struct packed {
      meas_mode_e mode;
      logic       falling;
   } meas_cfg_t;
endpackage

// File: rtl/pmt_edge.sv
`timescale 1ns/1ps
module pmt_edge
   import pmt_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      async_i,
   input  meas_cfg_t cfg_i,
   output logic      edge_o
);
   localparam int CHAIN_W = SYNC_STAGES + 1;

   // stages 0..SYNC_STAGES-1 synchronize, the last stage keeps the previous value
   logic [CHAIN_W-1:0] chain_q;
   logic               cur, prev, rise, fall;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[CHAIN_W-2:0], async_i};
   end

   assign cur  = chain_q[SYNC_STAGES-1];
   assign prev = chain_q[SYNC_STAGES];
   assign rise = cur & ~prev;
   assign fall = ~cur & prev;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pmt_edge: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_comb begin
      if (cfg_i.mode == MEAS_WIDTH) edge_o = rise | fall;
      else if (cfg_i.falling)       edge_o = fall;
      else                          edge_o = rise;
   end
endmodule

// File: rtl/pmt_ctrl.sv
`timescale 1ns/1ps
module pmt_ctrl
   import pmt_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      tick_i,
   input  logic      start_we_i,
   input  logic      start_i,
   input  logic      cfg_we_i,
   input  meas_cfg_t cfg_i,
   input  logic      cfg_ovf_i,
   input  logic      ovf_evt_i,
   output logic      run_o,
   output logic      start_pulse_o,
   output meas_cfg_t cfg_o,
   output logic      flag_o
);
   logic      run_q, flag_q, armed_q, clr_req;
   meas_cfg_t cfg_q;

   assign start_pulse_o = start_we_i & start_i & ~run_q;
   assign clr_req       = cfg_we_i & ~cfg_ovf_i & run_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q <= 1'b0;
         cfg_q <= '{mode: MEAS_PERIOD, falling: 1'b0};
      end else begin
         if (cfg_we_i && !run_q) cfg_q <= cfg_i;
         if (start_we_i)         run_q <= start_i;
      end
   end

   // armed: a tick has passed since the last overflow, so a clear may land
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
      end else if (ovf_evt_i) begin
         flag_q  <= 1'b1;
         armed_q <= 1'b0;
      end else if (clr_req && armed_q) begin
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
      end else if (flag_q && run_q && tick_i) begin
         armed_q <= 1'b1;
      end
   end

   assign run_o  = run_q;
   assign cfg_o  = cfg_q;
   assign flag_o = flag_q;

   assert_cfg_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q |=> $stable(cfg_q));
   assert_flag_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_evt_i |=> flag_q);
   assert_flag_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flag_q) |-> $past(cfg_we_i && !cfg_ovf_i && run_q));
endmodule

// File: rtl/pmt_count.sv
`timescale 1ns/1ps
module pmt_count #(
   parameter int W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         run_i,
   input  logic         tick_i,
   input  logic         edge_i,
   input  logic         start_pulse_i,
   output logic         ovf_evt_o,
   output logic [W-1:0] cnt_o,
   output logic [W-1:0] cap_o,
   output logic         irq_o
);
   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

   logic [W-1:0] cnt_q, cap_q;
   logic         irq_q, seen_q, hit;

   assign hit       = run_i & edge_i;
   assign ovf_evt_o = run_i & tick_i & (cnt_q == CNT_MAX);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         cap_q  <= '0;
         irq_q  <= 1'b0;
         seen_q <= 1'b0;
      end else begin
         irq_q <= (hit & seen_q) | ovf_evt_o;
         if (start_pulse_i)  seen_q <= 1'b0;
         else if (hit)       seen_q <= 1'b1;
         if (hit) begin
            cap_q <= cnt_q;
            cnt_q <= '0;
         end else if (run_i && tick_i) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign cnt_o = cnt_q;
   assign cap_o = cap_q;
   assign irq_o = irq_q;

   assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i || (!tick_i && !edge_i)) |=> $stable(cnt_q));
   assert_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit |=> (cnt_q == '0));
   assert_irq_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_q |-> $past(run_i && (edge_i || tick_i)));
   assert_first_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit && !seen_q && !tick_i) |=> !irq_q);
   assert_coincide_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit && tick_i && cnt_q == CNT_MAX) |=> (irq_q && cap_q == CNT_MAX));
endmodule

// File: rtl/pulse_capture_timer.sv
`timescale 1ns/1ps
module pulse_capture_timer
   import pmt_pkg::*;
#(
   parameter int W           = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         tick_i,
   input  logic         meas_i,
   input  logic         start_we_i,
   input  logic         start_i,
   input  logic         cfg_we_i,
   input  logic         cfg_width_i,
   input  logic         cfg_falling_i,
   input  logic         cfg_ovf_i,
   output logic         running_o,
   output logic         cfg_width_o,
   output logic         cfg_falling_o,
   output logic         ovf_flag_o,
   output logic [W-1:0] count_o,
   output logic [W-1:0] capture_o,
   output logic         irq_o
);
   generate
      if (W < 2) begin : g_bad_width
         $error("pulse_capture_timer: W must be at least 2");
      end
   endgenerate

   meas_cfg_t cfg_wr, cfg_cur;
   logic      run, start_pulse, edge_evt, ovf_evt;

   assign cfg_wr.mode    = cfg_width_i ? MEAS_WIDTH : MEAS_PERIOD;
   assign cfg_wr.falling = cfg_falling_i;

   pmt_ctrl u_ctrl (
      .clk_i, .rst_ni, .tick_i, .start_we_i, .start_i, .cfg_we_i,
      .cfg_i(cfg_wr), .cfg_ovf_i, .ovf_evt_i(ovf_evt),
      .run_o(run), .start_pulse_o(start_pulse), .cfg_o(cfg_cur), .flag_o(ovf_flag_o)
   );

   pmt_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk_i, .rst_ni, .async_i(meas_i), .cfg_i(cfg_cur), .edge_o(edge_evt)
   );

   pmt_count #(.W(W)) u_count (
      .clk_i, .rst_ni, .run_i(run), .tick_i, .edge_i(edge_evt),
      .start_pulse_i(start_pulse), .ovf_evt_o(ovf_evt),
      .cnt_o(count_o), .cap_o(capture_o), .irq_o
   );

   assign running_o     = run;
   assign cfg_width_o   = (cfg_cur.mode == MEAS_WIDTH);
   assign cfg_falling_o = cfg_cur.falling;
endmodule

// File: tb/sim_pulse_capture_timer.sv
`timescale 1ns/1ps
module sim_pulse_capture_timer;
   localparam int W = 8;
   localparam int MAXV = (1 << W) - 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic tick = 0, meas = 0, start_we = 0, start_v = 0;
   logic cfg_we = 0, cfg_width = 0, cfg_falling = 0, cfg_ovf = 0;
   logic running, width_o, falling_o, flag;
   logic [W-1:0] count, capture;
   logic irq;

   int checks = 0, fails = 0, irq_seen = 0, base = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   pulse_capture_timer #(.W(W), .SYNC_STAGES(2)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .meas_i(meas),
      .start_we_i(start_we), .start_i(start_v), .cfg_we_i(cfg_we),
      .cfg_width_i(cfg_width), .cfg_falling_i(cfg_falling), .cfg_ovf_i(cfg_ovf),
      .running_o(running), .cfg_width_o(width_o), .cfg_falling_o(falling_o),
      .ovf_flag_o(flag), .count_o(count), .capture_o(capture), .irq_o(irq)
   );

   always @(negedge clk) if (irq) irq_seen++;

   function automatic int gap_capture(int gap);
      return gap - 1;
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic nstep(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic do_reset();
      rst_n = 0; tick = 0; meas = 0; start_we = 0; start_v = 0;
      cfg_we = 0; cfg_width = 0; cfg_falling = 0; cfg_ovf = 0;
      nstep(3);
      rst_n = 1;
      nstep(1);
   endtask

   task automatic set_run(bit v);
      start_we = 1; start_v = v;
      nstep(1);
      start_we = 0;
   endtask

   task automatic write_cfg(bit w, bit f, bit o);
      cfg_we = 1; cfg_width = w; cfg_falling = f; cfg_ovf = o;
      nstep(1);
      cfg_we = 0;
   endtask

   task automatic run_to_flag();
      for (int i = 0; i < 400; i++) begin
         if (flag) break;
         nstep(1);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int cap_keep, gap, prev_gap;
      void'($urandom(32'd4711));
      do_reset();
      // R1 reset state
      chk("R1 running", running, 0);
      chk("R1 count", count, 0);
      chk("R1 capture", capture, 0);
      chk("R1 flag", flag, 0);
      chk("R1 irq", irq, 0);
      chk("R1 mode", {width_o, falling_o}, 0);

      // R3 counting under tick control
      set_run(1);
      nstep(5);
      chk("R3 no tick holds", count, 0);
      tick = 1;
      nstep(10);
      chk("R3 ten ticks", count, 10);
      set_run(0);
      nstep(5);
      chk("R3 stopped holds", count, 11);
      tick = 0;

      // R2 configuration only while stopped
      write_cfg(1, 1, 1);
      chk("R2 stopped write", {width_o, falling_o}, 3);
      set_run(1);
      write_cfg(0, 0, 1);
      chk("R2 running write ignored", {width_o, falling_o}, 3);
      set_run(0);
      write_cfg(0, 0, 1);
      chk("R2 write after stop", {width_o, falling_o}, 0);

      // R4 R5 R7 period mode, rising polarity
      do_reset();
      base = irq_seen;
      set_run(1);
      tick = 1;
      nstep(2);
      meas = 1;
      nstep(3);
      chk("R7 first edge no irq", irq_seen - base, 0);
      chk("R4 restart on edge", count, 0);
      cap_keep = capture;
      nstep(7);
      meas = 0;
      nstep(3);
      chk("R5 falling ignored count", count, 10);
      chk("R5 falling ignored capture", capture, cap_keep);
      chk("R5 falling ignored irq", irq_seen - base, 0);
      nstep(17);
      meas = 1;
      nstep(3);
      chk("R4 period capture", capture, gap_capture(30));
      chk("R4 restart", count, 0);
      chk("R4 one irq", irq_seen - base, 1);

      // R5 R7 period mode, falling polarity
      set_run(0);
      write_cfg(0, 1, 1);
      set_run(1);
      nstep(2);
      meas = 0;
      nstep(3);
      chk("R7 first falling no irq", irq_seen - base, 1);
      nstep(5);
      meas = 1;
      nstep(3);
      chk("R5 rising ignored", irq_seen - base, 1);
      nstep(14);
      meas = 0;
      nstep(3);
      chk("R5 falling capture", capture, gap_capture(25));
      chk("R5 falling irq", irq_seen - base, 2);

      // R8 R9 overflow and flag clear rules
      do_reset();
      base = irq_seen;
      set_run(1);
      tick = 1;
      run_to_flag();
      tick = 0;
      chk("R8 flag set", flag, 1);
      chk("R8 wrap to zero", count, 0);
      chk("R8 overflow irq before edge", irq_seen - base, 1);
      write_cfg(0, 0, 0);
      chk("R9 clear without tick ignored", flag, 1);
      tick = 1;
      nstep(1);
      tick = 0;
      write_cfg(0, 0, 1);
      chk("R9 write one no effect", flag, 1);
      write_cfg(0, 0, 0);
      chk("R9 clear after tick", flag, 0);
      tick = 1;
      run_to_flag();
      chk("R8 second overflow", flag, 1);
      nstep(1);
      set_run(0);
      tick = 0;
      write_cfg(0, 0, 0);
      chk("R9 clear while stopped ignored", flag, 1);
      set_run(1);
      write_cfg(0, 0, 0);
      chk("R9 clear after restart", flag, 0);

      // R10 edge and overflow in the same cycle
      do_reset();
      set_run(1);
      tick = 1;
      nstep(1);
      meas = 1;
      nstep(3);
      meas = 0;
      for (int i = 0; i < 300; i++) begin
         if (count == MAXV) break;
         nstep(1);
      end
      tick = 0;
      chk("R10 setup count", count, MAXV);
      base = irq_seen;
      meas = 1;
      nstep(2);
      tick = 1;
      nstep(1);
      tick = 0;
      chk("R10 capture max", capture, MAXV);
      chk("R10 restart", count, 0);
      chk("R10 flag", flag, 1);
      chk("R10 irq pulse", irq_seen - base, 1);
      nstep(2);
      chk("R10 single request", irq_seen - base, 1);

      // R6 width mode with random gaps
      do_reset();
      write_cfg(1, 0, 1);
      set_run(1);
      tick = 1;
      nstep(1);
      base = irq_seen;
      prev_gap = 0;
      for (int k = 0; k < 20; k++) begin
         meas = ~meas;
         nstep(3);
         if (k == 0) chk("R7 width first edge", irq_seen - base, 0);
         else        chk("R6 width capture", capture, gap_capture(prev_gap));
         gap = 4 + int'($urandom % 60);
         nstep(gap - 3);
         prev_gap = gap;
      end
      chk("R6 width irq count", irq_seen - base, 19);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule